// File: doc/BRIEF.md
# SPI Hold-Condition Synchroniser

This block sits between the pins of an SPI slave and its serial engine. It brings chip select, serial clock, the active-low hold input and the serial data input into a faster system clock domain through multi-stage synchronisers. It then turns serial clock edges into single-cycle strobes for the engine. A rising edge gives a shift strobe that samples input. A falling edge gives a drive strobe that advances the output.

When the host pulls hold low during a transfer, the block freezes the engine at the next point where the serial clock is low. From then on it issues no strobes and turns off the output enable, so the data output pin floats. The engine's bit counter and shift register keep their values. When hold is released, again aligned to a low serial clock, the transfer continues from where it stopped.

If the host deselects the device while it is frozen, the block raises a one-cycle logic-reset request and locks the interface. The lock lasts until hold is released while the device is deselected. A small byte assembler is included as the engine's front end. It collects bits MSB first and shows that a byte split by a hold still arrives intact.

Top module: `spi_hold_gate`

## Requirements
- R1: After a synchronous reset, `shift_en_o`, `drive_step_o`, `out_en_o`, `hold_o`, `logic_rst_o` and `byte_valid_o` are all 0.
- R2: While selected and not frozen, every serial clock rising edge gives exactly one `shift_en_o` pulse and every falling edge gives exactly one `drive_step_o` pulse. After each group of BYTE_W shifts, `byte_valid_o` pulses for one cycle with `byte_o` holding the bits in arrival order, the first bit in the MSB.
- R3: With chip select high, a low hold input never sets `hold_o`.
- R4: If hold goes low while selected and the serial clock is low, `hold_o` rises and `out_en_o` falls within SYNC_STAGES+1 system clock cycles.
- R5: If hold goes low while the serial clock is high, `hold_o` stays 0 until the serial clock goes low, and then rises.
- R6: If hold is released while the serial clock is low, `hold_o` clears and `out_en_o` returns to 1. If it is released while the serial clock is high, `hold_o` stays 1 until the serial clock goes low.
- R7: While frozen, serial clock edges produce no `shift_en_o` and no `drive_step_o`, and `out_en_o` is 0.
- R8: The bit count and partial byte survive a hold, so a byte interrupted at any bit position, in either entry phase and either exit phase, is delivered with its correct value.
- R9: Chip select going high while frozen gives exactly one one-cycle `logic_rst_o` pulse and discards the partial byte.
- R10: After such a reset, selecting the device again while hold is still low leaves it locked: no strobes and `out_en_o` at 0. Normal operation returns only after hold is released while deselected.
- R11: A normal deselect (not frozen) discards a partial byte without raising `logic_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select pin, active low |
| sclk_i | input | 1 | Serial clock pin |
| hold_n_i | input | 1 | Hold pin, active low |
| mosi_i | input | 1 | Serial data input pin |
| shift_en_o | output | 1 | One-cycle strobe: sample input bit (serial clock rise) |
| rx_bit_o | output | 1 | Synchronised input bit, valid with `shift_en_o` |
| drive_step_o | output | 1 | One-cycle strobe: advance output bit (serial clock fall) |
| out_en_o | output | 1 | Enable for the serial data output driver |
| hold_o | output | 1 | Hold condition active |
| logic_rst_o | output | 1 | One-cycle reset request for the serial logic |
| byte_valid_o | output | 1 | One-cycle strobe: a byte has been assembled |
| byte_o | output | BYTE_W | Assembled byte, first bit in the MSB |

## Verification
The bench builds the block with SYNC_STAGES=2 and BYTE_W=8. With these values a byte has only eight bit slots, so every hold placement can be covered. The bench freezes a byte after each bit position, enters with the serial clock high or low, and leaves with it high or low. That gives 32 interrupted bytes, each with its own computed value. Two-stage synchronisation keeps the pin-to-output latency at three system cycles, so every hold-phase check can be sampled inside one serial half-period. Further runs cover deselect during hold, the lockout, and plain deselect with a partial byte.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_RUN    = 2'd1,
    HS_FROZEN = 2'd2,
    HS_LOCKED = 2'd3
  } hold_state_e;
endpackage

// File: rtl/hold_pin_sync.sv
module hold_pin_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hold_edge_det.sv
module hold_edge_det #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign rise[g] = lvl[g] & ~prev[g];
    assign fall[g] = ~lvl[g] & prev[g];
  end
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  input  logic sclk_s,
  input  logic hold_n_s,
  input  logic sclk_rise,
  input  logic sclk_fall,
  output logic shift_en,
  output logic drive_step,
  output logic out_en,
  output logic frozen,
  output logic logic_rst,
  output logic frame_clr
);
  hold_state_e state, nxt;
  logic rst_req;

  always_comb begin
    nxt     = state;
    rst_req = 1'b0;
    unique case (state)
      HS_IDLE:   if (!cs_n_s) nxt = HS_RUN;
      HS_RUN: begin
        if (cs_n_s)                    nxt = HS_IDLE;
        else if (!hold_n_s && !sclk_s) nxt = HS_FROZEN;
      end
      HS_FROZEN: begin
        if (cs_n_s) begin
          nxt     = HS_LOCKED;
          rst_req = 1'b1;
        end else if (hold_n_s && !sclk_s) begin
          nxt = HS_RUN;
        end
      end
      HS_LOCKED: if (cs_n_s && hold_n_s) nxt = HS_IDLE;
      default:   nxt = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= HS_IDLE;
      shift_en   <= 1'b0;
      drive_step <= 1'b0;
      out_en     <= 1'b0;
      frozen     <= 1'b0;
      logic_rst  <= 1'b0;
      frame_clr  <= 1'b1;
    end else begin
      state      <= nxt;
      shift_en   <= (state == HS_RUN) && !cs_n_s && sclk_rise;
      drive_step <= (state == HS_RUN) && !cs_n_s && sclk_fall && hold_n_s;
      out_en     <= (nxt == HS_RUN);
      frozen     <= (nxt == HS_FROZEN);
      logic_rst  <= rst_req;
      frame_clr  <= (nxt == HS_IDLE) || (nxt == HS_LOCKED);
    end
  end

  // R7: no strobes while frozen
  assert_frozen_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    frozen |-> (!shift_en && !drive_step && !out_en));
  // R3: hold only entered or kept while selected
  assert_hold_needs_select_R3: assert property (@(posedge clk) disable iff (rst)
    frozen |-> $past(!cs_n_s));
  // R5: entry aligned to a low serial clock
  assert_entry_low_clock_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(frozen) |-> $past(!sclk_s));
  // R6: exit aligned to a low serial clock unless caused by deselect
  assert_exit_low_clock_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(frozen) && !logic_rst) |-> $past(!sclk_s));
  // R9: reset request is a single pulse
  assert_rst_single_R9: assert property (@(posedge clk) disable iff (rst)
    logic_rst |=> !logic_rst);
endmodule

// File: rtl/hold_byte_asm.sv
module hold_byte_asm #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift,
  input  logic              bit_in,
  output logic              valid,
  output logic [BYTE_W-1:0] data
);
  localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sreg;
  logic [BYTE_W-1:0] sreg_nxt;

  assign sreg_nxt = {sreg[BYTE_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sreg  <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (shift) begin
        sreg <= sreg_nxt;
        if (cnt == LAST) begin
          cnt   <= '0;
          valid <= 1'b1;
          data  <= sreg_nxt;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R2: a full group of shifts yields a byte strobe
  assert_byte_on_last_R2: assert property (@(posedge clk) disable iff (rst)
    (shift && !clr && cnt == LAST) |=> valid);
  // R8: a byte strobe always follows a shift
  assert_valid_after_shift_R8: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(shift));
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              hold_n_i,
  input  logic              mosi_i,
  output logic              shift_en_o,
  output logic              rx_bit_o,
  output logic              drive_step_o,
  output logic              out_en_o,
  output logic              hold_o,
  output logic              logic_rst_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int PINS = 4;
  localparam logic [PINS-1:0] PIN_IDLE = 4'b0101;

  logic [PINS-1:0] pins_s;
  logic cs_n_s, sclk_s, hold_n_s, mosi_s;
  logic sclk_rise, sclk_fall;
  logic frame_clr;
  logic rx_bit_q;

  hold_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst),
    .din({mosi_i, hold_n_i, sclk_i, cs_n_i}),
    .dout(pins_s)
  );

  assign cs_n_s   = pins_s[0];
  assign sclk_s   = pins_s[1];
  assign hold_n_s = pins_s[2];
  assign mosi_s   = pins_s[3];

  hold_edge_det #(.WIDTH(1), .RST_VAL(1'b0)) u_edge (
    .clk(clk), .rst(rst), .lvl(sclk_s), .rise(sclk_rise), .fall(sclk_fall)
  );

  hold_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cs_n_s(cs_n_s), .sclk_s(sclk_s), .hold_n_s(hold_n_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .shift_en(shift_en_o), .drive_step(drive_step_o), .out_en(out_en_o),
    .frozen(hold_o), .logic_rst(logic_rst_o), .frame_clr(frame_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_bit_q <= 1'b0;
    else     rx_bit_q <= mosi_s;
  end
  assign rx_bit_o = rx_bit_q;

  hold_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst(rst), .clr(frame_clr), .shift(shift_en_o),
    .bit_in(rx_bit_q), .valid(byte_valid_o), .data(byte_o)
  );

  // R9: the reset request appears only on deselect out of a hold
  assert_rst_from_hold_R9: assert property (@(posedge clk) disable iff (rst)
    logic_rst_o |-> $past(hold_o));
  // R11: a byte is never delivered in the cycle after a reset request
  assert_no_byte_after_rst_R11: assert property (@(posedge clk) disable iff (rst)
    logic_rst_o |=> !byte_valid_o);
endmodule

// File: tb/tb_spi_hold_gate.sv
`timescale 1ns/1ps
module tb_spi_hold_gate;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, hold_n = 1'b1, mosi = 1'b0;
  logic shift_en, rx_bit, drive_step, out_en, hold, lrst, bvalid;
  logic [7:0] bdata;

  int vectors = 0, fails = 0;
  int shift_cnt = 0, drive_cnt = 0, rst_cnt = 0, byte_cnt = 0;
  logic [7:0] last_byte = 8'h00;

  always #2 clk = ~clk;

  spi_hold_gate #(.SYNC_STAGES(2), .BYTE_W(8)) dut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .hold_n_i(hold_n),
    .mosi_i(mosi), .shift_en_o(shift_en), .rx_bit_o(rx_bit),
    .drive_step_o(drive_step), .out_en_o(out_en), .hold_o(hold),
    .logic_rst_o(lrst), .byte_valid_o(bvalid), .byte_o(bdata)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (shift_en)   shift_cnt++;
      if (drive_step) drive_cnt++;
      if (lrst)       rst_cnt++;
      if (bvalid) begin byte_cnt++; last_byte = bdata; end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      mosi = d[7-i]; tick(H); sclk = 1'b1; tick(H); sclk = 1'b0;
    end
    tick(H);
  endtask

  task automatic hold_body(input bit ex_high);
    int s0, d0;
    s0 = shift_cnt; d0 = drive_cnt;
    for (int k = 0; k < 3; k++) begin
      mosi = ~mosi; sclk = 1'b1; tick(H); sclk = 1'b0; tick(H);
    end
    check_eq("R7 shifts frozen", shift_cnt, s0);
    check_eq("R7 drives frozen", drive_cnt, d0);
    if (ex_high) begin
      sclk = 1'b1; tick(H); hold_n = 1'b1; tick(H);
      check_eq("R6 exit waits low clock", hold, 1);
      sclk = 1'b0; tick(H);
      check_eq("R6 exit after clock low", hold, 0);
    end else begin
      hold_n = 1'b1; tick(H);
      check_eq("R6 exit on low clock", hold, 0);
    end
    check_eq("R6 output re-enabled", out_en, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tick(5); rst = 1'b0; tick(2);
    check_eq("R1 shift_en", shift_en, 0);
    check_eq("R1 drive_step", drive_step, 0);
    check_eq("R1 out_en", out_en, 0);
    check_eq("R1 hold", hold, 0);
    check_eq("R1 logic_rst", lrst, 0);
    check_eq("R1 byte_valid", bvalid, 0);

    // R3: hold while deselected
    hold_n = 1'b0; tick(H);
    for (int k = 0; k < 4; k++) begin sclk = 1'b1; tick(H); sclk = 1'b0; tick(H); end
    check_eq("R3 hold ignored deselected", hold, 0);
    check_eq("R3 no shifts deselected", shift_cnt, 0);
    hold_n = 1'b1; tick(H);

    // R2: plain bytes
    cs_n = 1'b0; tick(H);
    check_eq("R2 out_en when selected", out_en, 1);
    for (int b = 0; b < 8; b++) begin
      logic [7:0] d;
      int s0, d0, c0;
      d = 8'((b * 37) ^ 8'hC3);
      s0 = shift_cnt; d0 = drive_cnt; c0 = byte_cnt;
      send_byte(d);
      check_eq("R2 shift count", shift_cnt - s0, 8);
      check_eq("R2 drive count", drive_cnt - d0, 8);
      check_eq("R2 byte count", byte_cnt - c0, 1);
      check_eq("R2 byte value", last_byte, d);
    end
    cs_n = 1'b1; tick(H);

    // R4..R8: sweep hold position, entry phase, exit phase
    for (int pos = 0; pos < 8; pos++) begin
      for (int ent = 0; ent < 2; ent++) begin
        for (int ex = 0; ex < 2; ex++) begin
          logic [7:0] d;
          int c0;
          d = 8'(pos * 53 + ent * 17 + ex * 101 + 8'h3C);
          c0 = byte_cnt;
          cs_n = 1'b0; tick(H);
          for (int i = 0; i < 8; i++) begin
            mosi = d[7-i]; tick(H); sclk = 1'b1; tick(H);
            if (i == pos && ent == 1) begin
              hold_n = 1'b0; tick(H);
              check_eq("R5 no entry while clock high", hold, 0);
              sclk = 1'b0; tick(H);
              check_eq("R5 entry after clock low", hold, 1);
              check_eq("R7 output off in hold", out_en, 0);
              hold_body(ex == 1);
            end else begin
              sclk = 1'b0;
              if (i == pos) begin
                tick(H); hold_n = 1'b0; tick(H);
                check_eq("R4 entry on low clock", hold, 1);
                check_eq("R4 output off in hold", out_en, 0);
                hold_body(ex == 1);
              end
            end
          end
          tick(H);
          check_eq("R8 split byte count", byte_cnt - c0, 1);
          check_eq("R8 split byte value", last_byte, d);
          cs_n = 1'b1; tick(H);
        end
      end
    end

    // R9: deselect during hold
    begin
      int r0, s0, c0;
      r0 = rst_cnt; c0 = byte_cnt;
      cs_n = 1'b0; tick(H);
      for (int i = 0; i < 3; i++) begin
        mosi = 1'b1; tick(H); sclk = 1'b1; tick(H); sclk = 1'b0;
      end
      tick(H); hold_n = 1'b0; tick(H);
      check_eq("R9 frozen before deselect", hold, 1);
      cs_n = 1'b1; tick(H);
      check_eq("R9 one reset pulse", rst_cnt - r0, 1);
      check_eq("R9 hold cleared", hold, 0);
      // R10: reselect with hold still low stays locked
      s0 = shift_cnt;
      cs_n = 1'b0; tick(H);
      for (int k = 0; k < 8; k++) begin sclk = 1'b1; tick(H); sclk = 1'b0; tick(H); end
      check_eq("R10 no shifts while locked", shift_cnt, s0);
      check_eq("R10 output off while locked", out_en, 0);
      check_eq("R10 no byte while locked", byte_cnt, c0);
      cs_n = 1'b1; hold_n = 1'b1; tick(H);
      cs_n = 1'b0; tick(H);
      check_eq("R10 output back after release", out_en, 1);
      send_byte(8'h5A);
      check_eq("R9 partial byte discarded", last_byte, 8'h5A);
      check_eq("R10 byte after release", byte_cnt - c0, 1);
      cs_n = 1'b1; tick(H);
    end

    // R11: plain deselect with partial byte
    begin
      int r0;
      r0 = rst_cnt;
      cs_n = 1'b0; tick(H);
      for (int i = 0; i < 5; i++) begin
        mosi = 1'b0; tick(H); sclk = 1'b1; tick(H); sclk = 1'b0;
      end
      tick(H); cs_n = 1'b1; tick(H);
      check_eq("R11 no reset request", rst_cnt, r0);
      cs_n = 1'b0; tick(H);
      send_byte(8'h96);
      check_eq("R11 partial discarded", last_byte, 8'h96);
      cs_n = 1'b1; tick(H);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule